// File: doc/BRIEF.md
# Video-Contention Memory Delay Generator

This block reproduces the memory-sharing timing of a home-computer video controller. Each clock tick is one CPU half-cycle. A free-running timebase counts half-cycles within a line, lines within a frame, and frames. When the CPU begins a memory access, the block works out how many half-cycles that access must be held off. The access is held off only when it falls on a display line, inside the per-line stretch where the video controller reads RAM, and targets a 16 KB bank that shares memory with video. The block also raises a frame interrupt pulse at a fixed point in the frame.

Horizontal position 0 marks the start of the contention window. The first video fetch of a line comes 12 half-cycles later, at position 12. The window lasts 258 half-cycles. Inside it, the stall is read from a 16-entry pattern indexed by the position modulo 16. The decision is not taken in the strobe cycle but one half-cycle later, which models the falling edge of the memory request. That later position is the one used.

Two small state machines drive the behaviour. The access sampler has states ST_IDLE and ST_SAMPLE:
- A strobe moves it from ST_IDLE to ST_SAMPLE.
- A further strobe keeps it in ST_SAMPLE.
- A cycle without a strobe returns it to ST_IDLE.

The interrupt generator has states IRQ_WAIT and IRQ_HIGH:
- It moves from IRQ_WAIT to IRQ_HIGH when the timebase is one half-cycle short of the interrupt point.
- It returns from IRQ_HIGH to IRQ_WAIT when its pulse counter runs out.

Top module: `contention_delay_gen`

## Requirements
- R1: `hpos_o` advances by one every clock from 0 to 455. After 455 it returns to 0 and `line_o` increments.
- R2: `line_o` runs from 0 to 310. When position (310,455) is passed, `line_o` returns to 0 and `frame_o` increments.
- R3: While `rst_n` is low, `hpos_o`, `line_o`, `frame_o`, `irq_o`, `stall_valid_o` and `stall_hc_o` are all 0.
- R4: A strobe seen in a cycle where the timebase shows (L,H) is judged at the position one half-cycle later (H+1, wrapping into the next line and frame). Its result appears with `stall_valid_o` high exactly two clocks after the strobe cycle. Strobes on consecutive cycles each give one result.
- R5: On a contended access at judged position P with P < 258, the stall is entry P mod 16 of the pattern. With P >= 258 the stall is 0.
- R6: The default pattern, entries 0 to 15, is 2,1,0,0,14,13,12,11,10,9,8,7,6,5,4,3 half-cycles.
- R7: Address bits [15:14] select bit 0 to 3 of `bank_contended_i`. When that bit is 0 the stall is 0.
- R8: Only access kinds 1 (opcode fetch start), 2 (read start) and 3 (write start) can stall. Kinds 0 and 4 to 7 give a result of 0, still with `stall_valid_o`.
- R9: Only judged lines 0 to 191 are display lines. Any other line gives a stall of 0.
- R10: `irq_o` rises when the timebase shows line 248, position 4. That point is 113080 half-cycles after the first fetch of line 0. `irq_o` stays high for exactly 64 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_start_i | input | 1 | Access-start strobe |
| acc_kind_i | input | 3 | Access kind: 1 opcode, 2 read, 3 write, others not checked |
| acc_addr_i | input | 16 | Access address |
| bank_contended_i | input | 4 | One flag per 16 KB bank |
| stall_valid_o | output | 1 | Stall result valid |
| stall_hc_o | output | 4 | Stall in half-cycles |
| irq_o | output | 1 | Frame interrupt pulse |
| hpos_o | output | 9 | Half-cycle position in line |
| line_o | output | 9 | Line number in frame |
| frame_o | output | 8 | Frame count |

## Verification
The strobe judgement and the timebase wrap can land in the same cycle. A strobe issued at position 455 of line 191 is judged at position 0 of line 192, which is blank, so the stall must be 0. A strobe at position 455 of a display line is judged on the next display line and must read pattern entry 0. The bench provokes both cases by waiting for those exact positions. It also issues strobes while `irq_o` is high, and checks that the pulse and the stall results do not disturb each other. Every expected stall comes from a reference model that uses the port-visible position at the moment of the strobe.

// File: rtl/ctn_pkg.sv
package ctn_pkg;
    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_OPCODE  = 3'd1,
        ACC_READ    = 3'd2,
        ACC_WRITE   = 3'd3,
        ACC_REFRESH = 3'd4,
        ACC_IO      = 3'd5,
        ACC_INTACK  = 3'd6,
        ACC_OTHER   = 3'd7
    } acc_kind_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SAMPLE = 1'b1
    } smp_state_t;

    typedef enum logic {
        IRQ_WAIT = 1'b0,
        IRQ_HIGH = 1'b1
    } irq_state_t;

    function automatic logic kind_can_stall(input acc_kind_t k);
        return (k == ACC_OPCODE) || (k == ACC_READ) || (k == ACC_WRITE);
    endfunction
endpackage

// File: rtl/ctn_timebase.sv
module ctn_timebase #(
    parameter int LINE_HC = 456,
    parameter int LINES   = 311,
    parameter int FRAME_W = 8,
    localparam int HPOS_W = $clog2(LINE_HC),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [HPOS_W-1:0] hpos,
    output logic [LINE_W-1:0] line,
    output logic [FRAME_W-1:0] frame
);
    localparam logic [HPOS_W-1:0] H_LAST = HPOS_W'(LINE_HC - 1);
    localparam logic [LINE_W-1:0] L_LAST = LINE_W'(LINES - 1);

    logic line_end, frame_end;
    assign line_end  = (hpos == H_LAST);
    assign frame_end = line_end && (line == L_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos  <= '0;
            line  <= '0;
            frame <= '0;
        end else begin
            hpos <= line_end ? '0 : hpos + 1'b1;
            if (line_end) line <= (line == L_LAST) ? '0 : line + 1'b1;
            if (frame_end) frame <= frame + 1'b1;
        end
    end

    a_r1_hpos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos == H_LAST) |=> (hpos == '0));
    a_r1_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos != H_LAST) |=> $stable(line));
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos == H_LAST && line == L_LAST) |=> (line == '0));
endmodule

// File: rtl/ctn_sampler.sv
module ctn_sampler
    import ctn_pkg::*;
#(
    parameter int LINE_HC    = 456,
    parameter int LINES      = 311,
    parameter int DISP_LINES = 192,
    parameter int WIN_HC     = 258,
    parameter int DELAY_W    = 4,
    parameter int PAT_N      = 16,
    parameter logic [PAT_N*DELAY_W-1:0] PATTERN = 64'h3456789ABCDE0012,
    localparam int HPOS_W = $clog2(LINE_HC),
    localparam int LINE_W = $clog2(LINES),
    localparam int IDX_W  = $clog2(PAT_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HPOS_W-1:0]  hpos,
    input  logic [LINE_W-1:0]  line,
    input  logic               start,
    input  acc_kind_t          kind,
    input  logic               bank_hit,
    output logic               stall_valid,
    output logic [DELAY_W-1:0] stall_hc
);
    localparam logic [LINE_W-1:0] DISP_END = LINE_W'(DISP_LINES);
    localparam logic [HPOS_W-1:0] WIN_END  = HPOS_W'(WIN_HC);

    smp_state_t state_q, state_d;
    logic kind_ok_q, bank_ok_q;
    logic in_window, hit;
    logic [IDX_W-1:0] idx;
    logic [DELAY_W-1:0] pat_val;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = start ? ST_SAMPLE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            kind_ok_q <= 1'b0;
            bank_ok_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                kind_ok_q <= kind_can_stall(kind);
                bank_ok_q <= bank_hit;
            end
        end
    end

    // During ST_SAMPLE the timebase already shows the strobe position plus one.
    assign in_window = (line < DISP_END) && (hpos < WIN_END);
    assign hit       = kind_ok_q && bank_ok_q && in_window;
    assign idx       = IDX_W'(hpos % HPOS_W'(PAT_N));
    assign pat_val   = PATTERN[idx*DELAY_W +: DELAY_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_valid <= 1'b0;
            stall_hc    <= '0;
        end else begin
            stall_valid <= (state_q == ST_SAMPLE);
            stall_hc    <= (state_q == ST_SAMPLE && hit) ? pat_val : '0;
        end
    end

    a_r4_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE) |=> stall_valid);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (!stall_valid && stall_hc == '0));
    a_r5_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && hpos >= WIN_END) |=> (stall_hc == '0));
    a_r7_bank_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && !bank_ok_q) |=> (stall_hc == '0));
    a_r8_kind_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && !kind_ok_q) |=> (stall_hc == '0));
    a_r9_blank_line: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && line >= DISP_END) |=> (stall_hc == '0));
endmodule

// File: rtl/ctn_irq.sv
module ctn_irq
    import ctn_pkg::*;
#(
    parameter int LINE_HC       = 456,
    parameter int LINES         = 311,
    parameter int LEAD_HC       = 12,
    parameter int IRQ_BEFORE_HC = 28736,
    parameter int IRQ_PULSE_HC  = 64,
    localparam int HPOS_W  = $clog2(LINE_HC),
    localparam int LINE_W  = $clog2(LINES),
    localparam int CNT_W   = $clog2(IRQ_PULSE_HC),
    localparam int FRAME_HC = LINE_HC * LINES,
    localparam int IRQ_ABS  = (FRAME_HC - IRQ_BEFORE_HC + LEAD_HC) % FRAME_HC,
    localparam int PRE_ABS  = (IRQ_ABS + FRAME_HC - 1) % FRAME_HC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [LINE_W-1:0] line,
    output logic              irq
);
    localparam logic [HPOS_W-1:0] PRE_H = HPOS_W'(PRE_ABS % LINE_HC);
    localparam logic [LINE_W-1:0] PRE_L = LINE_W'(PRE_ABS / LINE_HC);
    localparam logic [HPOS_W-1:0] IRQ_H = HPOS_W'(IRQ_ABS % LINE_HC);
    localparam logic [LINE_W-1:0] IRQ_L = LINE_W'(IRQ_ABS / LINE_HC);
    localparam logic [CNT_W-1:0]  CNT_TOP = CNT_W'(IRQ_PULSE_HC - 1);

    irq_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic at_pre;

    assign at_pre = (hpos == PRE_H) && (line == PRE_L);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_WAIT: if (at_pre) state_d = IRQ_HIGH;
            IRQ_HIGH: if (cnt_q == '0) state_d = IRQ_WAIT;
            default:  state_d = IRQ_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            cnt_q <= '0;
        end else begin
            irq <= (state_d == IRQ_HIGH);
            if (state_q == IRQ_WAIT && state_d == IRQ_HIGH) cnt_q <= CNT_TOP;
            else if (state_q == IRQ_HIGH)                   cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r10_rise_point: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (hpos == IRQ_H && line == IRQ_L));
    a_r10_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cnt_q == '0) |=> !irq);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cnt_q != '0) |=> irq);
endmodule

// File: rtl/contention_delay_gen.sv
module contention_delay_gen
    import ctn_pkg::*;
#(
    parameter int LINE_HC       = 456,
    parameter int LINES         = 311,
    parameter int DISP_LINES    = 192,
    parameter int LEAD_HC       = 12,
    parameter int WIN_HC        = 258,
    parameter int IRQ_BEFORE_HC = 28736,
    parameter int IRQ_PULSE_HC  = 64,
    parameter int DELAY_W       = 4,
    parameter int PAT_N         = 16,
    parameter logic [PAT_N*DELAY_W-1:0] PATTERN = 64'h3456789ABCDE0012,
    parameter int FRAME_W       = 8,
    parameter int ADDR_W        = 16,
    parameter int BANKS         = 4,
    localparam int HPOS_W = $clog2(LINE_HC),
    localparam int LINE_W = $clog2(LINES),
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_start_i,
    input  logic [2:0]         acc_kind_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    input  logic [BANKS-1:0]   bank_contended_i,
    output logic               stall_valid_o,
    output logic [DELAY_W-1:0] stall_hc_o,
    output logic               irq_o,
    output logic [HPOS_W-1:0]  hpos_o,
    output logic [LINE_W-1:0]  line_o,
    output logic [FRAME_W-1:0] frame_o
);
    logic [BANK_W-1:0] bank_idx;
    logic bank_hit;

    assign bank_idx = BANK_W'(acc_addr_i >> (ADDR_W - BANK_W));
    assign bank_hit = bank_contended_i[bank_idx];

    ctn_timebase #(.LINE_HC(LINE_HC), .LINES(LINES), .FRAME_W(FRAME_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .hpos(hpos_o), .line(line_o), .frame(frame_o)
    );

    ctn_sampler #(
        .LINE_HC(LINE_HC), .LINES(LINES), .DISP_LINES(DISP_LINES), .WIN_HC(WIN_HC),
        .DELAY_W(DELAY_W), .PAT_N(PAT_N), .PATTERN(PATTERN)
    ) u_smp (
        .clk(clk), .rst_n(rst_n), .hpos(hpos_o), .line(line_o),
        .start(acc_start_i), .kind(acc_kind_t'(acc_kind_i)), .bank_hit(bank_hit),
        .stall_valid(stall_valid_o), .stall_hc(stall_hc_o)
    );

    ctn_irq #(
        .LINE_HC(LINE_HC), .LINES(LINES), .LEAD_HC(LEAD_HC),
        .IRQ_BEFORE_HC(IRQ_BEFORE_HC), .IRQ_PULSE_HC(IRQ_PULSE_HC)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .hpos(hpos_o), .line(line_o), .irq(irq_o)
    );
endmodule

// File: tb/test_contention_delay_gen.sv
`timescale 1ns/1ps
module test_contention_delay_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_start_i = 1'b0;
    logic [2:0] acc_kind_i = 3'd0;
    logic [15:0] acc_addr_i = 16'h0;
    logic [3:0] bank_contended_i = 4'h0;
    logic stall_valid_o, irq_o;
    logic [3:0] stall_hc_o;
    logic [8:0] hpos_o, line_o;
    logic [7:0] frame_o;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit done = 0;

    always #5 clk = ~clk;

    contention_delay_gen i_contention_delay_gen (
        .clk(clk), .rst_n(rst_n), .acc_start_i(acc_start_i), .acc_kind_i(acc_kind_i),
        .acc_addr_i(acc_addr_i), .bank_contended_i(bank_contended_i),
        .stall_valid_o(stall_valid_o), .stall_hc_o(stall_hc_o), .irq_o(irq_o),
        .hpos_o(hpos_o), .line_o(line_o), .frame_o(frame_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R6 pattern
    function automatic int pat(input int i);
        if (i == 0) return 2;
        if (i == 1) return 1;
        if (i < 4) return 0;
        return 18 - i;
    endfunction

    function automatic int ref_stall(input int k, input logic [15:0] a, input logic [3:0] m,
                                     input int l, input int h);
        int p = h + 1;
        int ln = l;
        if (p == 456) begin p = 0; ln = (l + 1) % 311; end  // R4 judge one half-cycle later
        if (k < 1 || k > 3) return 0;                        // R8
        if (!m[a[15:14]]) return 0;                           // R7
        if (ln >= 192) return 0;                             // R9
        if (p >= 258) return 0;                              // R5
        return pat(p % 16);
    endfunction

    // driver: one strobe per call, lasting one cycle
    task automatic drive(input int k, input logic [15:0] a, input logic [3:0] m);
        acc_start_i = 1'b1;
        acc_kind_i = 3'(k);
        acc_addr_i = a;
        bank_contended_i = m;
        exp_q.push_back(ref_stall(k, a, m, int'(line_o), int'(hpos_o)));
        @(negedge clk);
    endtask

    task automatic idle();
        acc_start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_pos(input int l, input int h);
        while (!(int'(line_o) == l && int'(hpos_o) == h)) @(negedge clk);
    endtask

    // monitor / scoreboard (R4 timing: valid must line up with queued items)
    always @(negedge clk) begin
        if (rst_n && stall_valid_o) begin
            if (exp_q.size() == 0) check(0, "R4 unexpected valid", 1, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                check(int'(stall_hc_o) == e, "R5/R6 stall", int'(stall_hc_o), e);
            end
        end
    end

    initial begin
        int wd = 0;
        while (!done && wd < 190000) begin @(posedge clk); wd++; end
        if (!done) begin
            check(0, "watchdog", wd, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int h0, cnt;
        repeat (4) @(negedge clk);
        check(hpos_o == 0 && line_o == 0 && frame_o == 0, "R3 counters", int'(hpos_o), 0);
        check(!irq_o && !stall_valid_o && stall_hc_o == 0, "R3 outputs", int'(stall_hc_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        h0 = int'(hpos_o);
        @(negedge clk);
        check(int'(hpos_o) == h0 + 1, "R1 step", int'(hpos_o), h0 + 1);

        // R4/R5/R6: full sweep over display line 2 with back-to-back strobes
        wait_pos(1, 455);
        for (int i = 0; i < 457; i++) drive(2 + (i % 2), 16'h4000 + 16'(i), 4'b0010);
        idle(); idle(); idle();
        check(exp_q.size() == 0, "R4 count", exp_q.size(), 0);

        // R8: every kind, inside window
        wait_pos(5, 20);
        for (int k = 0; k < 8; k++) begin drive(k, 16'h4321, 4'b0010); idle(); end
        // R7: each bank against mask 1010
        for (int b = 0; b < 4; b++) begin drive(1, 16'(b) << 14, 4'b1010); idle(); end
        idle(); idle();

        // R1 line wrap
        wait_pos(6, 455);
        @(negedge clk);
        check(hpos_o == 0 && line_o == 7, "R1 wrap", int'(line_o), 7);

        // R9 boundary: judged at first blank line
        wait_pos(191, 455);
        drive(2, 16'h4000, 4'b0010);
        idle(); idle(); idle();

        // R9: blank-line sweep
        wait_pos(200, 0);
        for (int i = 0; i < 456; i++) drive(3, 16'h7FFF, 4'b1111);
        idle(); idle(); idle();

        // R10 interrupt with concurrent strobes
        while (!irq_o) @(negedge clk);
        check(line_o == 248 && hpos_o == 4, "R10 rise point", int'(hpos_o), 4);
        cnt = 0;
        while (irq_o) begin
            cnt++;
            if (cnt < 4) drive(1, 16'h4000, 4'b0010); else @(negedge clk);
            acc_start_i = 1'b0;
        end
        check(cnt == 64, "R10 width", cnt, 64);

        // R2 frame wrap
        wait_pos(310, 455);
        @(negedge clk);
        check(line_o == 0 && hpos_o == 0 && frame_o == 1, "R2 frame", int'(frame_o), 1);
        check(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule